// File: doc/BRIEF.md
# Buffered Down-Counting Timer Channel Set

The block holds five independent down-counting timer channels behind one word-addressed register port. Software writes a reload value (and, for channels 0 to 3, a compare value) into shadow buffers. Setting a channel's manual-update bit copies the buffers into the live counter and compare registers. Clearing that bit while setting start lets the channel run. Each channel decrements once per pulse on its own tick input, which is generated outside the block.

When a running channel sees a tick while its counter is zero, it expires. The expiry sets a status flag. With auto-reload enabled, the channel then reloads from its buffers and repeats. Without auto-reload, it stops at zero and clears its own start bit. Each status flag, gated by its enable bit, drives that channel's interrupt line. Channels 0 to 3 also drive a compare output, and an invert bit can flip its level. Software can read the live counter of every channel.

Top module: `dtimer_bank`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0, and `cmp_o` is 4'hF, because a zero counter sits at or below a zero compare value.
- R2: A write to a count buffer (byte offset 0x0C+12n) or to a compare buffer (0x10+12n, channels 0 to 3 only) reads back at that offset. The write leaves the live counter unchanged.
- R3: While a channel's manual-update bit is set, its counter and compare registers are loaded from its buffers on every cycle, and the channel does not count.
- R4: A channel with start=1 and manual-update=0 decrements its counter by one on each cycle where its tick input is high and the counter is non-zero. With no tick, or with start=0, the counter holds.
- R5: With auto-reload=1, the tick that finds the counter at zero reloads the counter and compare registers from the buffers. A buffered value N therefore gives a period of N+1 ticks, and a buffer written mid-period takes effect only at the next reload.
- R6: With auto-reload=0, the tick that finds the counter at zero leaves the counter at 0 and clears that channel's start bit. Later ticks change nothing. A control-register write in the same cycle takes priority over this clear.
- R7: The status register sits at 0x44. Enables occupy bits [4:0] and status flags occupy bits [9:5], where channel n uses bit 5+n. An expiry sets the channel's flag, and the flag reads as set from the next cycle. Writing 1 to a flag clears it. Writing 0 leaves it unchanged. An expiry wins over a clear in the same cycle.
- R8: `irq_o[n]` is high exactly while status flag n and enable bit n are both set.
- R9: `cmp_o[n]` (n = 0 to 3) is (counter <= compare) XOR the channel's invert bit.
- R10: The control register sits at 0x08. Each channel has a 4-bit field: bit 0 is start, bit 1 is manual update, bit 2 is output invert and bit 3 is auto-reload. Channel 0 uses bits [3:0], and channel k≥1 uses bits [4k+7:4k+4]. All other bits read 0.
- R11: The live counters of channels 0 to 3 read at 0x14+12n, zero-extended. Unmapped offsets read 0.
- R12: Channel 4 has a count buffer at 0x3C and no compare buffer. Its live counter reads at 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| tick_i | input | 5 | Per-channel count enable pulses |
| cmp_o | output | 4 | Compare outputs, channels 0 to 3 |
| irq_o | output | 5 | Per-channel interrupt lines |

## Verification
The hardest condition to create from the ports is an expiry arriving while other state is in flight. Examples are a one-shot channel clearing its own start bit while other channels keep running, and a reload picking up a buffer value that was rewritten mid-period. The stimulus drives tick pulses one channel mask at a time with exact pulse counts. This places each counter at zero on a known cycle. The bench can then read the control word, the status flags and the live counters immediately after the expiring tick, and again after further ticks that must have no effect.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int NCH = 5;
  localparam int DW  = 32;
  localparam int AW  = 8;

  localparam logic [AW-1:0] A_CTRL  = 8'h08;
  localparam logic [AW-1:0] A_LIVE4 = 8'h40;
  localparam logic [AW-1:0] A_IRQ   = 8'h44;

  typedef struct packed {
    logic reload;
    logic inv;
    logic upd;
    logic start;
  } ctl_t;

  function automatic logic [AW-1:0] a_cnt(input int n);
    return AW'(12 + 12 * n);
  endfunction

  function automatic logic [AW-1:0] a_cmp(input int n);
    return AW'(16 + 12 * n);
  endfunction

  function automatic logic [AW-1:0] a_live(input int n);
    return AW'(20 + 12 * n);
  endfunction

  // control field position: gap after channel 0
  function automatic int fpos(input int n);
    return (n == 0) ? 0 : 4 * (n + 1);
  endfunction

  function automatic logic [DW-1:0] ctrl_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int n = 0; n < NCH; n++) m[fpos(n) +: 4] = 4'hF;
    return m;
  endfunction
endpackage

// File: rtl/dtimer_chan.sv
module dtimer_chan
  import dtimer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctl_t             ctl_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_buf_i,
  input  logic [CNT_W-1:0] cmp_buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             cmp_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run;

  assign run      = ctl_i.start & ~ctl_i.upd;
  assign expire_o = run & tick_i & (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (ctl_i.upd) begin
      cnt_q <= cnt_buf_i;
    end else if (run && tick_i) begin
      if (cnt_q == '0) begin
        if (ctl_i.reload) cnt_q <= cnt_buf_i;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  generate
    if (HAS_CMP) begin : g_cmp
      logic [CNT_W-1:0] cmp_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 cmp_q <= '0;
        else if (ctl_i.upd)                          cmp_q <= cmp_buf_i;
        else if (expire_o && ctl_i.reload)           cmp_q <= cmp_buf_i;
      end
      assign cmp_o = (cnt_q <= cmp_q) ^ ctl_i.inv;
    end else begin : g_nocmp
      logic unused_cmp;
      assign unused_cmp = ^cmp_buf_i;
      assign cmp_o = 1'b0;
    end
  endgenerate

  AST_MAN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.upd |=> cnt_q == $past(cnt_buf_i)); // R3
  AST_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R4
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.upd && !(run && tick_i)) |=> $stable(cnt_q)); // R4
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && ctl_i.reload) |=> cnt_q == $past(cnt_buf_i)); // R5
  AST_ONESHOT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !ctl_i.reload) |=> cnt_q == '0); // R6
endmodule

// File: rtl/dtimer_irq.sv
module dtimer_irq
  import dtimer_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [NCH-1:0] evt_i,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] stat_o,
  output logic [NCH-1:0] irq_o
);
  logic [NCH-1:0] en_q, stat_q, clr;

  assign clr = wr_i ? wdata_i[2*NCH-1:NCH] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (wr_i) en_q <= wdata_i[NCH-1:0];
      stat_q <= (stat_q & ~clr) | evt_i; // set wins over clear
    end
  end

  assign en_o   = en_q;
  assign stat_o = stat_q;
  assign irq_o  = stat_q & en_q;

  AST_STAT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R7
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((stat_q & $past(wdata_i[2*NCH-1:NCH] & ~evt_i)) == '0)); // R7
  AST_NO_SPUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && evt_i == '0) |=> $stable(stat_q)); // R7
endmodule

// File: rtl/dtimer_bank.sv
module dtimer_bank
  import dtimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic [NCH-1:0] tick_i,
  output logic [NCH-2:0] cmp_o,
  output logic [NCH-1:0] irq_o
);
  localparam logic [DW-1:0] CMASK = ctrl_mask();
  localparam int NCMP = NCH - 1;

  logic [DW-1:0]    ctrl_q;
  logic [CNT_W-1:0] cnt_buf_q [NCH];
  logic [CNT_W-1:0] cmp_buf_q [NCMP];
  logic [CNT_W-1:0] live      [NCH];
  ctl_t             ctl       [NCH];
  logic [NCH-1:0]   expire, en, stat;
  logic             wr_ctrl, wr_irq;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_irq  = wr_en_i && (addr_i == A_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= wdata_i & CMASK;
    end else begin
      for (int n = 0; n < NCH; n++)
        if (expire[n] && !ctl[n].reload) ctrl_q[fpos(n)] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NCH; n++)  cnt_buf_q[n] <= '0;
      for (int n = 0; n < NCMP; n++) cmp_buf_q[n] <= '0;
    end else if (wr_en_i) begin
      for (int n = 0; n < NCH; n++)
        if (addr_i == a_cnt(n)) cnt_buf_q[n] <= wdata_i[CNT_W-1:0];
      for (int n = 0; n < NCMP; n++)
        if (addr_i == a_cmp(n)) cmp_buf_q[n] <= wdata_i[CNT_W-1:0];
    end
  end

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      assign ctl[n] = ctl_t'(ctrl_q[fpos(n) +: 4]);
      if (n < NCMP) begin : g_full
        dtimer_chan #(.CNT_W(CNT_W), .HAS_CMP(1'b1)) u_chan (
          .clk_i, .rst_ni,
          .ctl_i    (ctl[n]),
          .tick_i   (tick_i[n]),
          .cnt_buf_i(cnt_buf_q[n]),
          .cmp_buf_i(cmp_buf_q[n]),
          .cnt_o    (live[n]),
          .expire_o (expire[n]),
          .cmp_o    (cmp_o[n])
        );
      end else begin : g_bare
        logic unused_cmp;
        dtimer_chan #(.CNT_W(CNT_W), .HAS_CMP(1'b0)) u_chan (
          .clk_i, .rst_ni,
          .ctl_i    (ctl[n]),
          .tick_i   (tick_i[n]),
          .cnt_buf_i(cnt_buf_q[n]),
          .cmp_buf_i('0),
          .cnt_o    (live[n]),
          .expire_o (expire[n]),
          .cmp_o    (unused_cmp)
        );
      end

      AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire[n] && !ctl[n].reload && !wr_ctrl) |=> !ctrl_q[fpos(n)]); // R6
    end
  endgenerate

  dtimer_irq u_irq (
    .clk_i, .rst_ni,
    .wr_i   (wr_irq),
    .wdata_i(wdata_i),
    .evt_i  (expire),
    .en_o   (en),
    .stat_o (stat),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL)  rdata_o = ctrl_q;
    if (addr_i == A_IRQ)   rdata_o = DW'({stat, en});
    if (addr_i == A_LIVE4) rdata_o = DW'(live[NCH-1]);
    for (int n = 0; n < NCH; n++)
      if (addr_i == a_cnt(n)) rdata_o = DW'(cnt_buf_q[n]);
    for (int n = 0; n < NCMP; n++) begin
      if (addr_i == a_cmp(n))  rdata_o = DW'(cmp_buf_q[n]);
      if (addr_i == a_live(n)) rdata_o = DW'(live[n]);
    end
  end

  AST_CTRL_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & ~CMASK) == '0); // R10
endmodule

// File: tb/sim_dtimer_bank.sv
module sim_dtimer_bank;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [4:0]  tick_i = '0;
  logic [3:0]  cmp_o;
  logic [4:0]  irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    int          kind; // 0 rdata, 1 irq_o, 2 cmp_o
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  event  ev;

  always #(CLK_P/2) clk_i = ~clk_i;

  dtimer_bank u0 (.*);

  // monitor
  initial begin
    forever begin
      @(ev);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = (it.kind == 0) ? rdata_o :
              (it.kind == 1) ? 32'(irq_o) : 32'(cmp_o);
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic chk(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk_i);
    addr_i = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> ev;
    #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input logic [4:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tick_i = m;
    end
    @(negedge clk_i);
    tick_i = '0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk(0, 8'h08, 32'h0, "R1 ctrl");
    chk(0, 8'h44, 32'h0, "R1 irq reg");
    chk(0, 8'h0C, 32'h0, "R1 cnt buf0");
    chk(0, 8'h14, 32'h0, "R1 live0");
    chk(1, 8'h00, 32'h0, "R1 irq_o");
    chk(2, 8'h00, 32'hF, "R1 cmp_o");
    // R2 buffers
    wr(8'h0C, 32'd3);
    wr(8'h10, 32'd1);
    chk(0, 8'h0C, 32'd3, "R2 cnt buf0");
    chk(0, 8'h10, 32'd1, "R2 cmp buf0");
    chk(0, 8'h14, 32'd0, "R2 live0 untouched");
    // R3 manual update
    wr(8'h08, 32'h2);
    ticks(5'h01, 2);
    chk(0, 8'h14, 32'd3, "R3 live0 loaded, no count");
    chk(2, 8'h00, 32'hE, "R9 cmp0 low above compare");
    // R4 counting
    wr(8'h08, 32'h9);
    wr(8'h44, 32'h1);
    ticks(5'h01, 2);
    chk(0, 8'h14, 32'd1, "R4 live0 after 2 ticks");
    chk(2, 8'h00, 32'hF, "R9 cmp0 high at compare");
    ticks(5'h01, 1);
    chk(0, 8'h44, 32'h01, "R7 no flag before expiry");
    // R5 expiry and reload
    ticks(5'h01, 1);
    chk(0, 8'h14, 32'd3, "R5 reload after expiry");
    chk(0, 8'h44, 32'h21, "R7 flag set");
    chk(1, 8'h00, 32'h01, "R8 irq0 asserted");
    repeat (4) @(negedge clk_i);
    chk(0, 8'h14, 32'd3, "R4 hold without ticks");
    // R7 write 0 keeps flag, write 1 clears
    wr(8'h44, 32'h01);
    chk(0, 8'h44, 32'h21, "R7 write 0 keeps flag");
    wr(8'h44, 32'h21);
    chk(0, 8'h44, 32'h01, "R7 W1C clears flag");
    chk(1, 8'h00, 32'h0, "R8 irq0 dropped");
    // R5 period N+1
    ticks(5'h01, 3);
    chk(0, 8'h44, 32'h01, "R5 no expiry after N ticks");
    ticks(5'h01, 1);
    chk(0, 8'h44, 32'h21, "R5 expiry on tick N+1");
    chk(0, 8'h14, 32'd3, "R5 reloaded");
    // R5 new buffer only at next reload
    wr(8'h0C, 32'd1);
    chk(0, 8'h14, 32'd3, "R2 buffer write leaves live");
    ticks(5'h01, 4);
    chk(0, 8'h14, 32'd1, "R5 reload uses new buffer");
    // R9 invert
    wr(8'h08, 32'hD);
    chk(2, 8'h00, 32'hE, "R9 invert flips cmp0");
    // R6 one-shot on channel 1, field [11:8]
    wr(8'h18, 32'd2);
    wr(8'h1C, 32'd0);
    wr(8'h08, 32'h20D);
    chk(0, 8'h20, 32'd2, "R10 ch1 field manual, R11 live1");
    wr(8'h08, 32'h10D);
    ticks(5'h02, 3);
    chk(0, 8'h08, 32'h00D, "R6 start bit cleared");
    chk(0, 8'h20, 32'd0, "R6 live1 at zero");
    chk(0, 8'h44, 32'h61, "R7 ch1 flag set");
    chk(2, 8'h00, 32'hE, "R9 cmp1 high at zero");
    ticks(5'h02, 2);
    chk(0, 8'h20, 32'd0, "R6 later ticks ignored");
    chk(0, 8'h08, 32'h00D, "R6 stays stopped");
    wr(8'h44, 32'h02);
    chk(1, 8'h00, 32'h02, "R8 irq follows enable");
    // R12 channel 4
    wr(8'h3C, 32'd5);
    chk(0, 8'h3C, 32'd5, "R12 cnt buf4");
    wr(8'h08, 32'h20000D);
    chk(0, 8'h40, 32'd5, "R12 live4 loaded");
    wr(8'h08, 32'h90000D);
    ticks(5'h10, 2);
    chk(0, 8'h40, 32'd3, "R12 live4 counts");
    chk(0, 8'h08, 32'h90000D, "R10 ch4 field [23:20]");
    // R11 unmapped, R10 mask
    chk(0, 8'h00, 32'h0, "R11 unmapped reads 0");
    wr(8'h08, 32'hFFFFFFFF);
    chk(0, 8'h08, 32'h00FFFF0F, "R10 unused bits read 0");
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    finish_run();
  end
endmodule